// File: doc/BRIEF.md
# Dual-Rail Four-Phase Pipeline Stage

This block is one stage of a self-sequenced pipeline that carries an N-bit word with dual-rail encoding and a four-phase, return-to-zero handshake. No request line exists. Each data bit travels on a true rail and a false rail. A word whose every bit shows exactly one high rail is itself the request. A word whose every bit shows both rails low is the spacer that separates two tokens.

The stage is a clocked, synthesizable model of the clockless circuit. Every state-holding gate is a C-element register. It takes the value of its two inputs when they agree and otherwise keeps its last value. Each rail of each bit is latched by such a register, gated by the inverted acknowledge from the downstream stage. A reduction tree over the latched bits feeds one final C-element. That C-element raises the acknowledge to the upstream stage when the whole word is held, and drops it only after every bit has returned to spacer. Stages chain directly: one stage's `dn_*` rails connect to the next stage's `up_*` rails, and the next stage's `up_ack` connects back as `dn_ack`.

Top module: `dr_stage`

## Requirements
- R1: After reset, all downstream rails are low, `up_ack` is low and `code_err` is low.
- R2: A bit is valid when its two rails differ, and its value is then the true rail. Both rails low is the spacer. The output rails carry the latched word with the same encoding.
- R3: While `dn_ack` is low, a rail that goes high at the input appears high on the matching output rail one clock later.
- R4: While `dn_ack` is high, no output rail can rise, so a new token waits at the input until `dn_ack` falls.
- R5: Once latched, a high output rail stays high while `dn_ack` is low, even if the input has already returned to spacer.
- R6: `up_ack` rises one clock after the last bit of the word is latched valid, and never while any latched bit is spacer or illegal.
- R7: `up_ack` falls one clock after every latched bit has returned to spacer, and not before.
- R8: An output rail falls one clock after its input rail is low while `dn_ack` is high.
- R9: A latched bit with both rails high is an illegal code. It drives `code_err` high one clock after it is latched and does not count as valid for R6.
- R10: Three chained stages deliver a sequence of tokens to the far end in order and unchanged, for any acknowledge delays at either end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples all C-element state |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_t | input | WIDTH | True rails from the upstream stage |
| up_f | input | WIDTH | False rails from the upstream stage |
| up_ack | output | 1 | Completion acknowledge back to the upstream stage |
| dn_t | output | WIDTH | Latched true rails to the downstream stage |
| dn_f | output | WIDTH | Latched false rails to the downstream stage |
| dn_ack | input | 1 | Acknowledge from the downstream stage |
| code_err | output | 1 | High while any latched bit has both rails high |

## Verification
A faulty rail latch shows at the downstream rails in the cycle after the input changes. The symptom is a bit that appears early while `dn_ack` is high, or a held bit that drops before `dn_ack` rises. A faulty completion tree shows one clock later on `up_ack`. It can rise on a word that is only partly present, or fall while some bit still holds data. In a chain, either fault corrupts or reorders the tokens at the sink, or stalls the handshake so that it never completes.

// File: rtl/dr_pkg.sv
package dr_pkg;

   // One dual-rail bit holds a value when exactly one rail is high.
   function automatic logic dr_is_valid(input logic t, input logic f);
      return t ^ f;
   endfunction

   // Spacer: both rails low.
   function automatic logic dr_is_spacer(input logic t, input logic f);
      return ~(t | f);
   endfunction

   // Illegal: both rails high.
   function automatic logic dr_is_illegal(input logic t, input logic f);
      return t & f;
   endfunction

endpackage

// File: rtl/dr_celem.sv
module dr_celem (
   input  logic clk,
   input  logic rst_n,
   input  logic a,
   input  logic b,
   output logic y
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         y <= 1'b0;
      else if (a == b)
         y <= a;
   end

endmodule

// File: rtl/dr_bit_latch.sv
module dr_bit_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic in_t,
   input  logic in_f,
   input  logic ack_nxt,
   output logic q_t,
   output logic q_f
);

   logic open_n;
   assign open_n = ~ack_nxt;

   dr_celem i_c_true (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (in_t),
      .b     (open_n),
      .y     (q_t)
   );

   dr_celem i_c_false (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (in_f),
      .b     (open_n),
      .y     (q_f)
   );

   // R4: while downstream acknowledges, a low rail stays low
   p_no_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_nxt && !q_t) |=> !q_t);
   p_no_capture_f_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_nxt && !q_f) |=> !q_f);

   // R5: a held rail stays high until downstream acknowledges
   p_hold_t_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (q_t && !ack_nxt) |=> q_t);
   p_hold_f_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (q_f && !ack_nxt) |=> q_f);

endmodule

// File: rtl/dr_done_tree.sv
module dr_done_tree #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] q_t,
   input  logic [WIDTH-1:0] q_f,
   output logic             done,
   output logic             code_err
);
   import dr_pkg::*;

   localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
   localparam int LEAVES = 1 << LEVELS;
   localparam int NODES  = 2 * LEAVES - 1;

   initial begin
      if (WIDTH < 1) $error("dr_done_tree: WIDTH must be at least 1");
   end

   // Heap-ordered reduction: node 0 is the root, leaves start at LEAVES-1.
   logic [NODES-1:0] all_full;
   logic [NODES-1:0] all_empty;
   logic [WIDTH-1:0] bad;

   for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
      if (g < WIDTH) begin : g_real
         assign all_full[LEAVES-1+g]  = dr_is_valid(q_t[g], q_f[g]);
         assign all_empty[LEAVES-1+g] = dr_is_spacer(q_t[g], q_f[g]);
         assign bad[g]                = dr_is_illegal(q_t[g], q_f[g]);
      end else begin : g_pad
         assign all_full[LEAVES-1+g]  = 1'b1;
         assign all_empty[LEAVES-1+g] = 1'b1;
      end
   end

   for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
      assign all_full[n]  = all_full[2*n+1]  & all_full[2*n+2];
      assign all_empty[n] = all_empty[2*n+1] & all_empty[2*n+2];
   end

   logic not_empty;
   assign not_empty = ~all_empty[0];

   // Final C-element: rises on a complete word, falls on a complete spacer.
   dr_celem i_c_done (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (all_full[0]),
      .b     (not_empty),
      .y     (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_err <= 1'b0;
      else
         code_err <= |bad;
   end

endmodule

// File: rtl/dr_stage.sv
module dr_stage #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] up_t,
   input  logic [WIDTH-1:0] up_f,
   output logic             up_ack,
   output logic [WIDTH-1:0] dn_t,
   output logic [WIDTH-1:0] dn_f,
   input  logic             dn_ack,
   output logic             code_err
);

   initial begin
      if (WIDTH < 1) $error("dr_stage: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      dr_bit_latch i_latch (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_t    (up_t[b]),
         .in_f    (up_f[b]),
         .ack_nxt (dn_ack),
         .q_t     (dn_t[b]),
         .q_f     (dn_f[b])
      );
   end

   dr_done_tree #(.WIDTH(WIDTH)) i_done (
      .clk      (clk),
      .rst_n    (rst_n),
      .q_t      (dn_t),
      .q_f      (dn_f),
      .done     (up_ack),
      .code_err (code_err)
   );

   // R6: acknowledge rises only after a fully valid latched word
   p_ack_rise_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(up_ack) |-> $past((dn_t ^ dn_f) == {WIDTH{1'b1}}));

   // R7: acknowledge falls only after a full spacer
   p_ack_fall_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(up_ack) |-> $past((dn_t | dn_f) == '0));

   // R9: a latched illegal bit is reported
   p_err_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((dn_t & dn_f) != '0) |=> code_err);

endmodule

// File: tb/test_dr_stage.sv
module test_dr_stage;

   localparam int W    = 8;
   localparam int NTOK = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done_run = 0;

   // single stage under directed test
   logic [W-1:0] in_t = '0, in_f = '0;
   logic         nx_ack = 1'b0;
   logic [W-1:0] o_t, o_f;
   logic         s_ack, s_err;

   dr_stage #(.WIDTH(W)) i_dr_stage (
      .clk(clk), .rst_n(rst_n), .up_t(in_t), .up_f(in_f), .up_ack(s_ack),
      .dn_t(o_t), .dn_f(o_f), .dn_ack(nx_ack), .code_err(s_err));

   // three-stage chain
   logic [W-1:0] c_t [4];
   logic [W-1:0] c_f [4];
   logic         c_ack [4];
   logic         c_err [3];
   logic [W-1:0] src_t = '0, src_f = '0;
   logic         snk_ack = 1'b0;

   assign c_t[0] = src_t;
   assign c_f[0] = src_f;
   assign c_ack[3] = snk_ack;

   for (genvar s = 0; s < 3; s++) begin : g_chain
      dr_stage #(.WIDTH(W)) i_chain (
         .clk(clk), .rst_n(rst_n), .up_t(c_t[s]), .up_f(c_f[s]),
         .up_ack(c_ack[s]), .dn_t(c_t[s+1]), .dn_f(c_f[s+1]),
         .dn_ack(c_ack[s+1]), .code_err(c_err[s]));
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done_run) begin
         done_run = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      in_t = '0; in_f = '0; nx_ack = 1'b1;
      tick(3);
      nx_ack = 1'b0;
      tick(2);
   endtask

   task automatic t_reset();
      tick(1);
      chk(o_t == '0 && o_f == '0, "R1 rails", {o_t, o_f}, 0);
      chk(s_ack == 1'b0, "R1 ack", s_ack, 0);
      chk(s_err == 1'b0, "R1 err", s_err, 0);
   endtask

   task automatic t_token(input logic [W-1:0] v, input logic [W-1:0] v2);
      in_t = v; in_f = ~v; nx_ack = 1'b0;
      tick(1);
      chk(o_t == v && o_f == ~v, "R3 capture", {o_t, o_f}, {v, ~v});
      chk(s_ack == 1'b0, "R6 ack not yet", s_ack, 0);
      tick(1);
      chk(s_ack == 1'b1, "R6 ack rise", s_ack, 1);
      in_t = '0; in_f = '0;
      tick(2);
      chk(o_t == v && o_f == ~v, "R5 hold", {o_t, o_f}, {v, ~v});
      chk(s_ack == 1'b1, "R7 ack held", s_ack, 1);
      nx_ack = 1'b1;
      tick(1);
      chk(o_t == '0 && o_f == '0, "R8 return", {o_t, o_f}, 0);
      chk(s_ack == 1'b1, "R7 ack one more", s_ack, 1);
      tick(1);
      chk(s_ack == 1'b0, "R7 ack fall", s_ack, 0);
      in_t = v2; in_f = ~v2;
      tick(2);
      chk(o_t == '0 && o_f == '0, "R4 blocked", {o_t, o_f}, 0);
      nx_ack = 1'b0;
      tick(1);
      chk(o_t == v2 && o_f == ~v2, "R2 value", {o_t, o_f}, {v2, ~v2});
      tick(1);
      drain();
   endtask

   task automatic t_partial();
      in_t = 8'h01; in_f = '0; nx_ack = 1'b0;
      tick(3);
      chk(o_t == 8'h01 && o_f == '0, "R3 partial bit", {o_t, o_f}, 16'h0100);
      chk(s_ack == 1'b0, "R6 partial word", s_ack, 0);
      in_f = 8'hFE;
      tick(1);
      chk(s_ack == 1'b0, "R6 last bit latch", s_ack, 0);
      tick(1);
      chk(s_ack == 1'b1, "R6 complete", s_ack, 1);
      drain();
      chk(s_ack == 1'b0, "R7 after drain", s_ack, 0);
   endtask

   task automatic t_illegal();
      in_t = 8'hA5 | 8'h08; in_f = ~8'hA5 | 8'h08; nx_ack = 1'b0;
      tick(1);
      chk(s_err == 1'b0, "R9 err delay", s_err, 0);
      tick(1);
      chk(s_err == 1'b1, "R9 err", s_err, 1);
      chk(s_ack == 1'b0, "R9 no ack", s_ack, 0);
      tick(2);
      chk(s_ack == 1'b0, "R9 still no ack", s_ack, 0);
      drain();
      chk(s_err == 1'b0, "R9 err clear", s_err, 0);
   endtask

   logic [W-1:0] tok [NTOK];

   task automatic t_chain();
      for (int i = 0; i < NTOK; i++) tok[i] = W'(i * 37 + 5);
      fork
         begin
            for (int i = 0; i < NTOK; i++) begin
               src_t = tok[i]; src_f = ~tok[i];
               while (c_ack[0] !== 1'b1) tick(1);
               tick($urandom_range(0, 3));
               src_t = '0; src_f = '0;
               while (c_ack[0] !== 1'b0) tick(1);
               tick($urandom_range(0, 2));
            end
         end
         begin
            for (int i = 0; i < NTOK; i++) begin
               while ((c_t[3] ^ c_f[3]) !== {W{1'b1}}) tick(1);
               chk(c_t[3] == tok[i] && c_f[3] == ~tok[i], "R10 token",
                   c_t[3], tok[i]);
               tick($urandom_range(0, 3));
               snk_ack = 1'b1;
               while ((c_t[3] | c_f[3]) !== '0) tick(1);
               tick($urandom_range(0, 3));
               snk_ack = 1'b0;
            end
         end
      join
   endtask

   // R6 in the chain: acknowledge never rises on a partly valid word
   logic prev_ack0 = 1'b0;
   always @(negedge clk) begin
      if (rst_n && c_ack[0] && !prev_ack0)
         chk((c_t[1] ^ c_f[1]) == {W{1'b1}}, "R6 chain ack full",
             c_t[1] ^ c_f[1], {W{1'b1}});
      prev_ack0 = c_ack[0];
   end

   initial begin
      tick(200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
   end

   initial begin
      tick(2);
      rst_n = 1'b1;
      t_reset();
      t_token(8'h3C, 8'hC1);
      t_token(8'hFF, 8'h00);
      t_partial();
      t_illegal();
      t_chain();
      tick(2);
      summary();
   end

endmodule